// File: doc/BRIEF.md
# Speculative In-Order Retirement Queue

This block keeps decoded operations of a small out-of-order core in program order between dispatch and retirement. Each dispatched operation gets a slot tag. Execution units later use that tag to report a result. Branch operations are completed by a resolve report that says whether the prediction held. Operations leave only from the oldest slot, and only once that slot is complete. A retiring operation that has a destination drives a write request to the architectural register file. Execution results therefore reach program state only at retirement.

When a branch resolves as mispredicted, the queue drops every operation younger than that branch in the same cycle. It raises a flush output that names the branch, and it rewinds the allocation point to the slot just after the branch. The branch itself stays in the queue and retires normally. The dropped operations never write program state, and reports that later name them are ignored.

Top module: `spec_retire_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_tag` is 0, and `commit_valid` and `flush_valid` are 0.
- R2: Dispatched operations receive consecutive tags in program order, starting at 0 and wrapping modulo 2^IDX_W. `disp_tag` shows the tag the next dispatch will take.
- R3: The queue holds 2^IDX_W operations. When it is full, `disp_ready` is 0 and a dispatch request is ignored.
- R4: `commit_valid` is 1 exactly when the oldest live operation is complete. At most one operation retires per cycle, and operations retire in dispatch order.
- R5: Completion in a different order from dispatch never lets a younger operation retire ahead of an incomplete older one.
- R6: A branch is completed only by a resolve report on its tag, never by a completion report. It retires with `commit_we` = 0.
- R7: A mispredict resolve on a live, unresolved branch sets `flush_valid` = 1 and `flush_tag` = the branch tag in that same cycle. It holds `disp_ready` at 0 for that cycle and discards every younger operation. The next dispatch then receives tag branch+1.
- R8: A completion report that names a slot holding no live non-branch operation has no effect. This covers flushed slots, retired slots and empty slots.
- R9: A resolve report that names a slot holding no live unresolved branch has no effect and raises no flush.
- R10: `commit_we` is 1 only for a retiring non-branch operation dispatched with a destination. `commit_dest` and `commit_value` then carry that operation's destination and the last value reported for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_is_branch | input | 1 | Dispatched operation is a branch |
| disp_writes | input | 1 | Dispatched operation has a register destination |
| disp_dest | input | REG_W | Destination register number |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | IDX_W | Tag for the next dispatched operation |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | IDX_W | Tag of completed operation |
| cmp_value | input | DATA_W | Result value |
| br_valid | input | 1 | Branch resolve report |
| br_tag | input | IDX_W | Tag of resolved branch |
| br_mispredict | input | 1 | 1 = mispredicted, 0 = prediction held |
| commit_valid | output | 1 | Oldest operation retires this cycle |
| commit_we | output | 1 | Register file write enable |
| commit_dest | output | REG_W | Register file write address |
| commit_value | output | DATA_W | Register file write data |
| flush_valid | output | 1 | Younger operations are being discarded |
| flush_tag | output | IDX_W | Tag of the mispredicted branch |

## Verification
The bench uses the default parameters: IDX_W = 4 (16 slots), DATA_W = 32 and REG_W = 5. With 16 slots, random traffic regularly fills the queue and wraps the tag past 15. This brings the full stall, flushes that cross the wrap point and reused tags within a few thousand cycles. Directed sequences add a flush from a branch at the head of the queue and late reports to flushed slots, which random traffic reaches only rarely.

// File: rtl/spec_retire_queue.sv
module spec_retire_queue #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_is_branch,
  input  logic              disp_writes,
  input  logic [REG_W-1:0]  disp_dest,
  output logic              disp_ready,
  output logic [IDX_W-1:0]  disp_tag,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              br_valid,
  input  logic [IDX_W-1:0]  br_tag,
  input  logic              br_mispredict,
  output logic              commit_valid,
  output logic              commit_we,
  output logic [REG_W-1:0]  commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_tag
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0]  head_q, tail_q;
  logic [DEPTH-1:0]  live_q, done_q, isbr_q, we_q;
  logic [DEPTH-1:0]  live_d, done_d, younger;
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];

  logic [PTR_W-1:0] count;
  logic [IDX_W-1:0] head_idx, tail_idx, br_off;
  logic retire, br_hit, cmp_hit, disp_fire;

  assign count     = tail_q - head_q;
  assign head_idx  = head_q[IDX_W-1:0];
  assign tail_idx  = tail_q[IDX_W-1:0];
  assign br_off    = br_tag - head_idx;
  assign retire    = live_q[head_idx] & done_q[head_idx];
  assign br_hit    = br_valid & live_q[br_tag] & isbr_q[br_tag] & ~done_q[br_tag];
  assign cmp_hit   = cmp_valid & live_q[cmp_tag] & ~isbr_q[cmp_tag];

  assign flush_valid = br_hit & br_mispredict;
  assign flush_tag   = br_tag;
  assign disp_ready  = (count != PTR_W'(DEPTH)) & ~flush_valid;
  assign disp_fire   = disp_valid & disp_ready;
  assign disp_tag    = tail_idx;

  assign commit_valid = retire;
  assign commit_we    = retire & we_q[head_idx] & ~isbr_q[head_idx];
  assign commit_dest  = dest_q[head_idx];
  assign commit_value = val_q[head_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    assign younger[i] = (IDX_W'(i) - head_idx) > br_off;
  end

  always_comb begin
    live_d = live_q;
    done_d = done_q;
    if (retire) live_d[head_idx] = 1'b0;
    if (cmp_hit) done_d[cmp_tag] = 1'b1;
    if (br_hit) done_d[br_tag] = 1'b1;
    if (flush_valid) live_d = live_d & ~younger;
    if (disp_fire) begin
      live_d[tail_idx] = 1'b1;
      done_d[tail_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      live_q <= '0;
      done_q <= '0;
    end else begin
      live_q <= live_d;
      done_q <= done_d;
      if (retire) head_q <= head_q + 1'b1;
      if (flush_valid) tail_q <= head_q + PTR_W'(br_off) + 1'b1;
      else if (disp_fire) tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_hit) val_q[cmp_tag] <= cmp_value;
    if (disp_fire) begin
      isbr_q[tail_idx] <= disp_is_branch;
      we_q[tail_idx]   <= disp_writes & ~disp_is_branch;
      dest_q[tail_idx] <= disp_dest;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTR_W'(DEPTH));

  assert_flush_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> tail_idx == $past(br_tag) + IDX_W'(1));

  assert_one_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head_q == $past(head_q) + PTR_W'(1));

  assert_commit_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> count != '0);

  assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> $past(tail_q) != tail_q || $past(count) == '0 || $past(br_off) == $past(count) - PTR_W'(1));
endmodule

// File: tb/spec_retire_queue_tb.sv
module spec_retire_queue_tb;
  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_is_branch = 0, disp_writes = 0;
  logic [4:0] disp_dest = 0;
  logic disp_ready;
  logic [3:0] disp_tag;
  logic cmp_valid = 0;
  logic [3:0] cmp_tag = 0;
  logic [31:0] cmp_value = 0;
  logic br_valid = 0, br_mispredict = 0;
  logic [3:0] br_tag = 0;
  logic commit_valid, commit_we, flush_valid;
  logic [4:0] commit_dest;
  logic [31:0] commit_value;
  logic [3:0] flush_tag;

  int checks = 0, errors = 0;
  logic [4:0] m_head, m_tail;
  logic [15:0] m_live, m_done, m_br, m_we;
  logic [4:0] m_dest [16];
  logic [31:0] m_val [16];

  always #10 clk = ~clk;

  spec_retire_queue u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ready(logic fl);
    return ((m_tail - m_head) != 5'd16) && !fl;
  endfunction

  task automatic model_reset();
    m_head = 0; m_tail = 0; m_live = 0; m_done = 0; m_br = 0; m_we = 0;
  endtask

  task automatic step(logic dv, logic dbr, logic dwe, logic [4:0] dd,
                      logic cv, logic [3:0] ct, logic [31:0] cval,
                      logic bv, logic [3:0] bt, logic bm);
    logic [3:0] h, boff, ti;
    logic ret, bhit, fl, chit, rdy;
    @(negedge clk);
    disp_valid = dv; disp_is_branch = dbr; disp_writes = dwe; disp_dest = dd;
    cmp_valid = cv; cmp_tag = ct; cmp_value = cval;
    br_valid = bv; br_tag = bt; br_mispredict = bm;
    #1;
    h = m_head[3:0];
    ti = m_tail[3:0];
    ret = m_live[h] & m_done[h];
    bhit = bv & m_live[bt] & m_br[bt] & ~m_done[bt];
    fl = bhit & bm;
    chit = cv & m_live[ct] & ~m_br[ct];
    rdy = exp_ready(fl);
    chk("R3/R7 disp_ready", disp_ready, rdy);
    chk("R2 disp_tag", disp_tag, ti);
    chk("R4/R5 commit_valid", commit_valid, ret);
    chk("R7/R9 flush_valid", flush_valid, fl);
    if (fl) chk("R7 flush_tag", flush_tag, bt);
    if (ret) begin
      chk("R6/R10 commit_we", commit_we, m_we[h]);
      if (m_we[h]) begin
        chk("R10 commit_dest", commit_dest, m_dest[h]);
        chk("R8/R10 commit_value", commit_value, m_val[h]);
      end
    end
    boff = bt - h;
    if (chit) begin m_done[ct] = 1; m_val[ct] = cval; end
    if (bhit) m_done[bt] = 1;
    if (ret) begin m_live[h] = 0; m_head = m_head + 1; end
    if (fl) begin
      for (int i = 0; i < 16; i++)
        if (4'(i - h) > boff) m_live[i] = 0;
      m_tail = {1'b0, h} + (m_head - m_head) + 5'(boff) + 5'd1;
      m_tail = (m_head - 5'(ret)) + 5'(boff) + 5'd1;
    end else if (dv && rdy) begin
      m_live[ti] = 1; m_done[ti] = 0; m_br[ti] = dbr;
      m_we[ti] = dwe & ~dbr; m_dest[ti] = dd;
      m_tail = m_tail + 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0,0,0,0, 0,0,0, 0,0,0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 disp_tag", disp_tag, 0);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 flush_valid", flush_valid, 0);
    // R2/R3: fill all 16 slots, then an extra dispatch is ignored
    for (int i = 0; i < 17; i++) step(1, i == 5, 1, 5'(i), 0,0,0, 0,0,0);
    // R5: complete younger slot 3 first, then the head
    step(0,0,0,0, 1, 4'd3, 32'h33, 0,0,0);
    idle(2);
    step(0,0,0,0, 1, 4'd0, 32'hA0, 0,0,0);
    step(0,0,0,0, 1, 4'd1, 32'hA1, 0,0,0);
    step(0,0,0,0, 1, 4'd2, 32'hA2, 0,0,0);
    step(0,0,0,0, 1, 4'd4, 32'hA4, 0,0,0);
    idle(3);
    // R6: completion on branch slot 5 ignored; R7: mispredict flushes 6..15
    step(0,0,0,0, 1, 4'd5, 32'hBAD, 0,0,0);
    idle(2);
    step(1,0,1,5'd9, 1, 4'd7, 32'h77, 1, 4'd5, 1);
    // R8: late completion on flushed slot; R9: resolve on flushed slot
    step(0,0,0,0, 1, 4'd9, 32'h99, 1, 4'd8, 1);
    idle(3);
    step(1,0,1,5'd3, 0,0,0, 0,0,0);
    idle(3);
    step(0,0,0,0, 1, 4'd6, 32'h66, 0,0,0);
    idle(3);
    // R7: branch at head mispredicts
    step(1,1,0,0, 0,0,0, 0,0,0);
    step(1,0,1,5'd1, 0,0,0, 0,0,0);
    step(1,0,1,5'd2, 0,0,0, 1, 4'd7, 1);
    idle(3);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] < 3'd5, r[4:3] == 2'b00, r[5], 5'(r[10:6]),
           r[12:11] != 2'b00, 4'(r[16:13] ^ m_head[3:0] & {4{r[17]}}), $urandom,
           r[20:18] < 3'd2, 4'(m_head[3:0] + 4'(r[24:21] & {2'b0, r[26:25]})), r[29:27] == 3'd0);
    end
    idle(40);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule